// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is the control half of one DMA channel. Software programs a source address, a destination address, a transfer count and a configuration word through a small register port. Those settings go into staging registers first. The working copies, meaning the current source, current destination and current count, are loaded from the staging registers only when the current count is zero. Because of this, software can queue the next job while the present one is still running.

The channel passes atomic transfers one at a time to an external data mover. It raises a one-cycle start pulse and presents the current addresses. The mover ends each transfer with a one-cycle done pulse. On each done pulse the count drops by one and both addresses advance by a programmable step. The channel turns itself off when the count runs out, unless auto-reload is enabled. A stop request never breaks into a transfer: it completes at the next transfer boundary and clears the on bit. Software waits on that bit to learn when the stop has really taken effect.

Requests come from a hardware request pin or from a self-clearing software trigger bit. A mode bit in the configuration word selects between the two sources.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every readable register reads 0 and no start pulse is issued. The register offsets are:
  - 0: control, with bit 2 = stop, bit 1 = on, bit 0 = trigger.
  - 1: staged source.
  - 2: staged destination.
  - 3: staged count.
  - 4: configuration, with bit 0 = auto-reload, bit 1 = software mode, bits 15:8 = address step.
  - 5: current source.
  - 6: current destination.
  - 7: current count.
- R2: In software mode, with the channel on and a nonzero count, writing the trigger bit starts exactly one atomic transfer. The trigger bit reads 0 from the cycle the start pulse appears.
- R3: A trigger write has no effect when hardware mode is selected or when the channel is off. It starts nothing, and the trigger bit reads back 0.
- R4: In hardware mode, a request pulse starts a transfer only while the channel is on and idle. Requests while the channel is off, while a transfer is in flight, or while software mode is selected are ignored.
- R5: Each done pulse lowers the current count by 1 and adds the step to both the current source and the current destination.
- R6: With auto-reload off, the on bit clears when the current count reaches 0, and no further start pulse is issued.
- R7: With auto-reload on, when the count reaches 0 the current count, source and destination are reloaded from the staging registers, and the channel stays on.
- R8: Writes to the staging registers leave the current registers untouched while the current count is nonzero. Writing the on bit while the current count is 0 loads all three current registers from the staging registers.
- R9: A stop written while a transfer is in flight leaves the on bit set and the stop bit reading 1 until the done pulse. At the done pulse, on and stop both read 0 and the current count, source and destination are all 0.
- R10: A stop written while the channel is idle takes effect in the next cycle: on reads 0 and all three current registers read 0.
- R11: The start pulse lasts one cycle, and no new start pulse is issued until the done pulse of the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_wdata | input | AW | Write data |
| reg_rdata | output | AW | Read data for reg_addr (combinational) |
| hw_req | input | 1 | Hardware request pulse |
| mv_start | output | 1 | One-cycle start pulse to the data mover |
| mv_src | output | AW | Source address of the transfer |
| mv_dst | output | AW | Destination address of the transfer |
| mv_done | input | 1 | One-cycle completion pulse from the data mover |

## Verification
The bench writes a stop while a transfer is in flight and checks that the on bit stays set until the done pulse. A design that stopped at once would clear the bit early, while the mover is still working. The bench changes the staging registers in the middle of a job and then reads the current registers. A design without double buffering would show the new addresses immediately. The bench also checks both ends of a job, using auto-reload on one and no reload on the other, to catch a channel that fails to turn itself off or that loses its reload. Finally, it sends triggers and hardware requests in the wrong mode, while the channel is off, and during a busy transfer. A design with poor request gating would issue extra start pulses, which the bench counts.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] RA_SRC  = 3'd1;
    localparam logic [REG_AW-1:0] RA_DST  = 3'd2;
    localparam logic [REG_AW-1:0] RA_CNT  = 3'd3;
    localparam logic [REG_AW-1:0] RA_CFG  = 3'd4;
    localparam logic [REG_AW-1:0] RA_CSRC = 3'd5;
    localparam logic [REG_AW-1:0] RA_CDST = 3'd6;
    localparam logic [REG_AW-1:0] RA_CCNT = 3'd7;

    localparam int STEP_W  = 8;
    localparam int STEP_LO = 8;

    typedef enum logic {SQ_IDLE, SQ_BUSY} seq_state_e;

    typedef enum logic [1:0] {CC_HOLD, CC_LOAD, CC_CLEAR, CC_ADV} cur_cmd_e;

    typedef struct packed {
        logic stop;
        logic on;
        logic trig;
    } ctrl_bits_t;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              sw_mode;
        logic              reload;
    } cfg_t;

    function automatic logic [15:0] cfg_word(cfg_t c);
        return {c.step, 6'b0, c.sw_mode, c.reload};
    endfunction

endpackage

// File: rtl/dma_chan_stage.sv
module dma_chan_stage
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [AW-1:0]     wr_data,
    output logic [AW-1:0]     stg_src,
    output logic [AW-1:0]     stg_dst,
    output logic [CW-1:0]     stg_cnt,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_src <= '0;
            stg_dst <= '0;
            stg_cnt <= '0;
            cfg     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_SRC: stg_src <= wr_data;
                RA_DST: stg_dst <= wr_data;
                RA_CNT: stg_cnt <= wr_data[CW-1:0];
                RA_CFG: begin
                    cfg.step    <= wr_data[STEP_LO +: STEP_W];
                    cfg.sw_mode <= wr_data[1];
                    cfg.reload  <= wr_data[0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma_chan_cur.sv
module dma_chan_cur
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  cur_cmd_e          cmd,
    input  logic [AW-1:0]     stg_src,
    input  logic [AW-1:0]     stg_dst,
    input  logic [CW-1:0]     stg_cnt,
    input  logic [STEP_W-1:0] step,
    output logic [AW-1:0]     cur_src,
    output logic [AW-1:0]     cur_dst,
    output logic [CW-1:0]     cur_cnt,
    output logic              cnt_zero,
    output logic              cnt_last
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [AW-1:0] step_ext;

    always_comb begin
        step_ext = AW'(step);
        cnt_zero = (cur_cnt == '0);
        cnt_last = (cur_cnt == CNT_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_src <= '0;
            cur_dst <= '0;
            cur_cnt <= '0;
        end else begin
            case (cmd)
                CC_LOAD: begin
                    cur_src <= stg_src;
                    cur_dst <= stg_dst;
                    cur_cnt <= stg_cnt;
                end
                CC_CLEAR: begin
                    cur_src <= '0;
                    cur_dst <= '0;
                    cur_cnt <= '0;
                end
                CC_ADV: begin
                    cur_src <= cur_src + step_ext;
                    cur_dst <= cur_dst + step_ext;
                    cur_cnt <= cur_cnt - CNT_ONE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  ctrl_bits_t ctrl_wdata,
    input  logic       sw_mode,
    input  logic       reload,
    input  logic       hw_req,
    input  logic       mv_done,
    input  logic       cnt_zero,
    input  logic       cnt_last,
    output ctrl_bits_t ctrl_q,
    output logic       mv_start,
    output logic       busy,
    output cur_cmd_e   cmd
);

    seq_state_e state;
    logic       stop_wr;
    logic       req;
    logic       start_go;
    logic       done_go;
    logic       stopping;

    always_comb begin
        busy     = (state == SQ_BUSY);
        stop_wr  = ctrl_wr & ctrl_wdata.stop;
        req      = sw_mode ? ctrl_q.trig : hw_req;
        start_go = !busy & ctrl_q.on & !ctrl_q.stop & !stop_wr & !cnt_zero & req;
        done_go  = busy & mv_done;
        stopping = ctrl_q.stop | stop_wr;

        cmd = CC_HOLD;
        if (done_go) begin
            if (stopping)
                cmd = CC_CLEAR;
            else if (cnt_last && reload)
                cmd = CC_LOAD;
            else
                cmd = CC_ADV;
        end else if (!busy && stop_wr) begin
            cmd = CC_CLEAR;
        end else if (ctrl_wr && ctrl_wdata.on && cnt_zero) begin
            cmd = CC_LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            ctrl_q   <= '0;
            mv_start <= 1'b0;
        end else begin
            mv_start <= start_go;

            if (start_go)
                state <= SQ_BUSY;
            else if (done_go)
                state <= SQ_IDLE;

            if (done_go && stopping) begin
                ctrl_q <= '0;
            end else if (done_go && cnt_last && !reload) begin
                ctrl_q.on   <= 1'b0;
                ctrl_q.trig <= 1'b0;
            end else if (stop_wr) begin
                ctrl_q.trig <= 1'b0;
                if (busy)
                    ctrl_q.stop <= 1'b1;
                else
                    ctrl_q.on <= 1'b0;
            end else if (ctrl_wr) begin
                ctrl_q.on   <= ctrl_wdata.on;
                ctrl_q.trig <= ctrl_wdata.trig & ctrl_wdata.on & sw_mode;
            end else if (start_go) begin
                ctrl_q.trig <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              hw_req,
    output logic              mv_start,
    output logic [AW-1:0]     mv_src,
    output logic [AW-1:0]     mv_dst,
    input  logic              mv_done
);

    logic [AW-1:0] stg_src;
    logic [AW-1:0] stg_dst;
    logic [CW-1:0] stg_cnt;
    cfg_t          cfg;
    logic [AW-1:0] cur_src;
    logic [AW-1:0] cur_dst;
    logic [CW-1:0] cur_cnt;
    logic          cnt_zero;
    logic          cnt_last;
    ctrl_bits_t    ctrl_q;
    ctrl_bits_t    ctrl_wdata;
    cur_cmd_e      cmd;
    logic          busy;
    logic          ctrl_wr;
    logic          ctl_on;
    logic          ctl_stop;

    always_comb begin
        ctrl_wr    = reg_wr && (reg_addr == RA_CTRL);
        ctrl_wdata = ctrl_bits_t'(reg_wdata[2:0]);
        ctl_on     = ctrl_q.on;
        ctl_stop   = ctrl_q.stop;
        mv_src     = cur_src;
        mv_dst     = cur_dst;
    end

    dma_chan_stage #(.AW(AW), .CW(CW)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .stg_src (stg_src),
        .stg_dst (stg_dst),
        .stg_cnt (stg_cnt),
        .cfg     (cfg)
    );

    dma_chan_cur #(.AW(AW), .CW(CW)) u_cur (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .stg_src  (stg_src),
        .stg_dst  (stg_dst),
        .stg_cnt  (stg_cnt),
        .step     (cfg.step),
        .cur_src  (cur_src),
        .cur_dst  (cur_dst),
        .cur_cnt  (cur_cnt),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    dma_chan_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .sw_mode    (cfg.sw_mode),
        .reload     (cfg.reload),
        .hw_req     (hw_req),
        .mv_done    (mv_done),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last),
        .ctrl_q     (ctrl_q),
        .mv_start   (mv_start),
        .busy       (busy),
        .cmd        (cmd)
    );

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = AW'(ctrl_q);
            RA_SRC:  reg_rdata = stg_src;
            RA_DST:  reg_rdata = stg_dst;
            RA_CNT:  reg_rdata = AW'(stg_cnt);
            RA_CFG:  reg_rdata = AW'(cfg_word(cfg));
            RA_CSRC: reg_rdata = cur_src;
            RA_CDST: reg_rdata = cur_dst;
            default: reg_rdata = AW'(cur_cnt);
        endcase
    end

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ctrl_wr,
    input logic          wr_stop,
    input logic          mv_start,
    input logic          mv_done,
    input logic          busy,
    input logic          ctl_on,
    input logic          ctl_stop,
    input logic          reload,
    input logic [CW-1:0] cur_cnt
);

    logic outst;
    logic stop_w;

    always_comb stop_w = ctrl_wr & wr_stop;

    always_ff @(posedge clk) begin
        if (rst)
            outst <= 1'b0;
        else if (mv_start)
            outst <= 1'b1;
        else if (mv_done)
            outst <= 1'b0;
    end

    a_r11_start_single: assert property (@(posedge clk) disable iff (rst)
        mv_start |=> !mv_start);

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
        mv_start |-> !outst);

    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        (outst && mv_done && cur_cnt > CW'(1) && !ctl_stop && !stop_w)
        |=> (cur_cnt == $past(cur_cnt) - CW'(1)));

    a_r6_auto_off: assert property (@(posedge clk) disable iff (rst)
        (outst && mv_done && cur_cnt == CW'(1) && !reload && !ctl_stop && !ctrl_wr)
        |=> !ctl_on);

    a_r7_reload_on: assert property (@(posedge clk) disable iff (rst)
        (outst && mv_done && cur_cnt == CW'(1) && reload && ctl_on && !ctl_stop && !ctrl_wr)
        |=> ctl_on);

    a_r9_stop_done: assert property (@(posedge clk) disable iff (rst)
        (outst && mv_done && ctl_stop)
        |=> (!ctl_on && !ctl_stop && cur_cnt == '0));

    a_r10_stop_idle: assert property (@(posedge clk) disable iff (rst)
        (stop_w && !busy) |=> (!ctl_on && cur_cnt == '0));

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (ctrl_wr),
    .wr_stop  (reg_wdata[2]),
    .mv_start (mv_start),
    .mv_done  (mv_done),
    .busy     (busy),
    .ctl_on   (ctl_on),
    .ctl_stop (ctl_stop),
    .reload   (cfg.reload),
    .cur_cnt  (cur_cnt)
);

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          hw_req = 1'b0;
    logic          mv_start;
    logic [AW-1:0] mv_src;
    logic [AW-1:0] mv_dst;
    logic          mv_done = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    int n_starts = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_ctrl #(.AW(AW), .CW(CW)) i_dma_chan_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hw_req    (hw_req),
        .mv_start  (mv_start),
        .mv_src    (mv_src),
        .mv_dst    (mv_dst),
        .mv_done   (mv_done)
    );

    always @(negedge clk) if (!rst && mv_start) n_starts++;

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [AW-1:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk);
        hw_req = 1'b1;
        @(negedge clk);
        hw_req = 1'b0;
    endtask

    task automatic wait_start(input string req);
        int k = 0;
        while (!mv_start && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk(req, AW'(mv_start), AW'(1));
    endtask

    task automatic finish_xfer();
        @(negedge clk);
        mv_done = 1'b1;
        @(negedge clk);
        mv_done = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 3'd0, 0);
        rd_chk("R1 cfg", 3'd4, 0);
        rd_chk("R1 csrc", 3'd5, 0);
        rd_chk("R1 cdst", 3'd6, 0);
        rd_chk("R1 ccnt", 3'd7, 0);
        chk("R1 start", AW'(mv_start), 0);
    endtask

    task automatic t_sw_flow();
        int s0;
        wr(3'd4, (4 << 8) | 2);
        wr(3'd1, 32'h1000);
        wr(3'd2, 32'h2000);
        wr(3'd3, 3);
        wr(3'd0, 32'h2);
        rd_chk("R8 load on turn-on cnt", 3'd7, 3);
        rd_chk("R8 load on turn-on src", 3'd5, 32'h1000);
        rd_chk("R2 on set", 3'd0, 32'h2);
        wr(3'd0, 32'h3);
        wait_start("R2 trig start");
        rd_chk("R2 trig self-clear", 3'd0, 32'h2);
        chk("R2 mover src", mv_src, 32'h1000);
        finish_xfer();
        rd_chk("R5 cnt", 3'd7, 2);
        rd_chk("R5 src", 3'd5, 32'h1004);
        rd_chk("R5 dst", 3'd6, 32'h2004);
        wr(3'd3, 5);
        wr(3'd1, 32'h3000);
        wr(3'd2, 32'h5000);
        rd_chk("R8 cnt held", 3'd7, 2);
        rd_chk("R8 src held", 3'd5, 32'h1004);
        wr(3'd0, 32'h3); wait_start("R2 second"); finish_xfer();
        wr(3'd0, 32'h3); wait_start("R2 third"); finish_xfer();
        rd_chk("R6 cnt zero", 3'd7, 0);
        rd_chk("R6 src advanced", 3'd5, 32'h100C);
        rd_chk("R6 auto off", 3'd0, 0);
        s0 = n_starts;
        wr(3'd0, 32'h1);
        idle(8);
        chk("R3 trig while off no start", AW'(n_starts - s0), 0);
        rd_chk("R3 trig while off reads 0", 3'd0, 0);
        wr(3'd0, 32'h2);
        rd_chk("R8 reload cnt", 3'd7, 5);
        rd_chk("R8 reload src", 3'd5, 32'h3000);
        rd_chk("R8 reload dst", 3'd6, 32'h5000);
        s0 = n_starts;
        pulse_req();
        idle(5);
        chk("R4 hw req in sw mode ignored", AW'(n_starts - s0), 0);
    endtask

    task automatic t_hw_flow();
        int s0;
        wr(3'd4, 8 << 8);
        s0 = n_starts;
        wr(3'd0, 32'h3);
        idle(6);
        chk("R3 trig in hw mode no start", AW'(n_starts - s0), 0);
        rd_chk("R3 trig in hw mode reads 0", 3'd0, 32'h2);
        s0 = n_starts;
        pulse_req();
        wait_start("R4 hw start");
        pulse_req();
        idle(2);
        finish_xfer();
        idle(5);
        chk("R4 req while busy ignored", AW'(n_starts - s0), 1);
        rd_chk("R5 hw cnt", 3'd7, 4);
        rd_chk("R5 hw src", 3'd5, 32'h3008);
        rd_chk("R5 hw dst", 3'd6, 32'h5008);
        wr(3'd0, 0);
        s0 = n_starts;
        pulse_req();
        idle(5);
        chk("R4 req while off ignored", AW'(n_starts - s0), 0);
        rd_chk("R4 cnt unchanged", 3'd7, 4);
    endtask

    task automatic t_reload();
        wr(3'd0, 32'h4);
        rd_chk("R10 idle stop on", 3'd0, 0);
        rd_chk("R10 idle stop cnt", 3'd7, 0);
        rd_chk("R10 idle stop src", 3'd5, 0);
        rd_chk("R10 idle stop dst", 3'd6, 0);
        wr(3'd4, (1 << 8) | 1);
        wr(3'd1, 32'h40);
        wr(3'd2, 32'h80);
        wr(3'd3, 2);
        wr(3'd0, 32'h2);
        pulse_req(); wait_start("R7 first"); finish_xfer();
        rd_chk("R7 mid cnt", 3'd7, 1);
        rd_chk("R7 mid src", 3'd5, 32'h41);
        pulse_req(); wait_start("R7 second"); finish_xfer();
        rd_chk("R7 reload cnt", 3'd7, 2);
        rd_chk("R7 reload src", 3'd5, 32'h40);
        rd_chk("R7 reload dst", 3'd6, 32'h80);
        rd_chk("R7 stays on", 3'd0, 32'h2);
    endtask

    task automatic t_stop_busy();
        int s0;
        wr(3'd4, (1 << 8) | 3);
        wr(3'd0, 32'h3);
        wait_start("R9 start");
        wr(3'd0, 32'h4);
        rd_chk("R9 stop pending, still on", 3'd0, 32'h6);
        rd_chk("R9 cnt kept during transfer", 3'd7, 2);
        finish_xfer();
        rd_chk("R9 stopped ctrl", 3'd0, 0);
        rd_chk("R9 cnt zero", 3'd7, 0);
        rd_chk("R9 src zero", 3'd5, 0);
        rd_chk("R9 dst zero", 3'd6, 0);
        s0 = n_starts;
        wr(3'd0, 32'h1);
        idle(6);
        chk("R11 no start after stop", AW'(n_starts - s0), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sw_flow();
        t_hw_flow();
        t_reload();
        t_stop_busy();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule